// File: doc/BRIEF.md
# ACPI Power-Management Event and Timer Block

This block holds the fixed power-management registers that firmware and the operating system reach through a 64-byte register window. It keeps a free-running PM timer, a status register with write-one-to-clear semantics, an enable register and a control register. A level-sensitive system control interrupt (SCI) is driven whenever an interrupting status bit is set together with its enable. The timer raises its status bit each time its top bit changes. After firmware clears that bit, the next change of the top bit raises it again.

Writing the control register with the sleep-enable bit set acts on the sleep type. Type 0 asks for a soft power-off. Type 1 records a power-button wake and asks for a reset. A separate APM command port turns the SCI-enable control bit on or off. A power-button event input, an RTC alarm input and a global-lock event input feed the status register. The timer advances on a tick-enable input, so an integrator can feed it from any clock divider.

Top module: `acpi_pm_evt`

## Requirements
- R1: After reset the status, enable and control registers read 0x0000, the timer reads 0, and `sci`, `soft_off_req` and `reset_req` are low.
- R2: Register fields sit at fixed 6-bit offsets. A 16-bit read (`size32`=0) returns status at 0x00, enable at 0x02 and control at 0x04. A 32-bit read (`size32`=1) at 0x08 returns the timer, zero-extended to 32 bits. Every other offset, and every other access size at these offsets, reads as zero. 32-bit writes have no effect.
- R3: The timer is TMR_W bits wide (24 by default). It adds one on every cycle in which `tick` is high, holds otherwise, and wraps from all-ones to zero.
- R4: A 16-bit write at 0x00 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R5: Status bit 0 (timer) is set one cycle after the timer's top bit differs from the armed value. The armed value is 0 after reset, so the first set comes when the count reaches 2^(TMR_W-1). The bit stays set until it is cleared.
- R6: The armed value is reloaded with the timer's current top bit only when a status write clears a timer-status bit that is set. After such a clear, the bit is set again only at the next change of the top bit.
- R7: `sci` is high exactly while some status bit among 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) is set and the enable bit at the same position is set.
- R8: A 16-bit write at 0x04 stores all control bits except bit 13 (sleep-enable), which always reads 0.
- R9: A control write with bit 13 set acts on the sleep type in bits 12:10. Type 0 raises `soft_off_req` for exactly the next cycle. Type 1 sets status bits 15 (wake) and 8 (power button) and raises `reset_req` for exactly the next cycle. Other types, and writes with bit 13 clear, raise neither request.
- R10: An APM command of 0xF1 sets control bit 0 (SCI enable). A command of 0xF0 clears it. Other command values change nothing.
- R11: A `pwrbtn_evt` pulse sets status bit 8 only when enable bit 8 is set.
- R12: An `rtc_evt` pulse sets status bit 10 and a `glbl_evt` pulse sets status bit 5, whatever the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance enable, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| size32 | input | 1 | Access size: 1 = 32-bit, 0 = 16-bit |
| addr | input | 6 | Byte offset inside the register window |
| wdata | input | 16 | Write data for 16-bit accesses |
| rdata | output | 32 | Read data for the current `addr`/`size32` |
| apm_wr | input | 1 | APM command strobe |
| apm_cmd | input | 8 | APM command byte |
| pwrbtn_evt | input | 1 | Power-button press event |
| rtc_evt | input | 1 | RTC alarm event |
| glbl_evt | input | 1 | Global-lock release event |
| sci | output | 1 | Level system control interrupt |
| soft_off_req | output | 1 | One-cycle soft power-off request |
| reset_req | output | 1 | One-cycle reset/resume request |

## Verification
The bench drives the timer across its top-bit change and across its wrap to zero, then clears the timer status. A design that never re-arms would raise that status again on the very next cycle, and a design that ignores the wrap would never raise it a second time. Status writes mix ones and zeros to catch a plain store in place of write-one-to-clear. Sleep-type writes cover types 0, 1 and 7, and a write with sleep-enable low, to expose a wrong type decode, a request that lasts too long or a sleep-enable bit that is stored. Reads at undecoded offsets and at mismatched access sizes, a 32-bit write to a live register, and a power-button press with its enable off all show up when a design decodes too loosely.

// File: rtl/acpi_pm_evt.sv
module acpi_pm_evt #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        size32,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic [31:0] rdata,
  input  logic        apm_wr,
  input  logic [7:0]  apm_cmd,
  input  logic        pwrbtn_evt,
  input  logic        rtc_evt,
  input  logic        glbl_evt,
  output logic        sci,
  output logic        soft_off_req,
  output logic        reset_req
);

  localparam int          TOP      = TMR_W - 1;
  localparam logic [15:0] SCI_MASK = 16'h0521;
  localparam logic [15:0] STS_MASK = 16'h8521;
  localparam logic [15:0] SLP_EN   = 16'h2000;

  logic [TMR_W-1:0] cnt_r;
  logic             arm_r;
  logic [15:0]      sts_r, en_r, ctl_r;
  logic [15:0]      set_v, clr_v;
  logic             soft_r, rst_r;

  wire wr16    = wr_en && !size32;
  wire wr_sts  = wr16 && addr == 6'h00;
  wire wr_en_r = wr16 && addr == 6'h02;
  wire wr_ctl  = wr16 && addr == 6'h04;
  wire slp_go  = wr_ctl && wdata[13];
  wire slp0    = slp_go && wdata[12:10] == 3'd0;
  wire slp1    = slp_go && wdata[12:10] == 3'd1;
  wire tmr_clr = wr_sts && wdata[0] && sts_r[0];
  wire tmr_hit = (cnt_r[TOP] != arm_r) && !tmr_clr;

  assign clr_v = wr_sts ? wdata : 16'h0000;

  always_comb begin
    set_v     = '0;
    set_v[0]  = tmr_hit;
    set_v[5]  = glbl_evt;
    set_v[8]  = (pwrbtn_evt && en_r[8]) || slp1;
    set_v[10] = rtc_evt;
    set_v[15] = slp1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      arm_r  <= 1'b0;
      sts_r  <= '0;
      en_r   <= '0;
      ctl_r  <= '0;
      soft_r <= 1'b0;
      rst_r  <= 1'b0;
    end else begin
      if (tick) cnt_r <= cnt_r + 1'b1;
      if (tmr_clr) arm_r <= cnt_r[TOP];
      sts_r <= ((sts_r & ~clr_v) | set_v) & STS_MASK;
      if (wr_en_r) en_r <= wdata;
      if (apm_wr && apm_cmd == 8'hF1)      ctl_r <= (wr_ctl ? (wdata & ~SLP_EN) : ctl_r) | 16'h0001;
      else if (apm_wr && apm_cmd == 8'hF0) ctl_r <= (wr_ctl ? (wdata & ~SLP_EN) : ctl_r) & 16'hFFFE;
      else if (wr_ctl)                     ctl_r <= wdata & ~SLP_EN;
      soft_r <= slp0;
      rst_r  <= slp1;
    end
  end

  always_comb begin
    rdata = '0;
    if (size32) begin
      if (addr == 6'h08) rdata[TMR_W-1:0] = cnt_r;
    end else begin
      case (addr)
        6'h00:   rdata[15:0] = sts_r;
        6'h02:   rdata[15:0] = en_r;
        6'h04:   rdata[15:0] = ctl_r;
        default: rdata = '0;
      endcase
    end
  end

  assign sci          = |(sts_r & en_r & SCI_MASK);
  assign soft_off_req = soft_r;
  assign reset_req    = rst_r;

endmodule

// File: rtl/acpi_pm_evt_chk.sv
module acpi_pm_evt_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic             size32,
  input logic [5:0]       addr,
  input logic [15:0]      wdata,
  input logic [31:0]      rdata,
  input logic             apm_wr,
  input logic [7:0]       apm_cmd,
  input logic             soft_off_req,
  input logic             reset_req,
  input logic [TMR_W-1:0] cnt
);

  // R9
  soft_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off_req |-> $past(rst_n && wr_en && !size32 && addr == 6'h04 && wdata[13] && wdata[12:10] == 3'd0));

  // R9
  reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(rst_n && wr_en && !size32 && addr == 6'h04 && wdata[13] && wdata[12:10] == 3'd1));

  // R3
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick)) |-> cnt == TMR_W'($past(cnt) + 1'b1));

  // R3
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick)) |-> $stable(cnt));

  // R10
  apm_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && apm_wr && apm_cmd == 8'hF1) |-> (!size32 && addr == 6'h04) |-> rdata[0]);

  // R10
  apm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && apm_wr && apm_cmd == 8'hF0) |-> (!size32 && addr == 6'h04) |-> !rdata[0]);

  // R8
  slp_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!size32 && addr == 6'h04) |-> !rdata[13]);

  // R2
  rd_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:24] == 8'h00);

endmodule

bind acpi_pm_evt acpi_pm_evt_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .size32(size32),
  .addr(addr), .wdata(wdata), .rdata(rdata), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
  .soft_off_req(soft_off_req), .reset_req(reset_req), .cnt(cnt_r)
);

// File: tb/acpi_pm_evt_test.sv
module acpi_pm_evt_test;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, size32 = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        apm_wr = 1'b0;
  logic [7:0]  apm_cmd = '0;
  logic        pwrbtn_evt = 1'b0, rtc_evt = 1'b0, glbl_evt = 1'b0;
  logic        sci, soft_off_req, reset_req;

  int checks = 0, fails = 0;
  bit mon_vld = 1'b0, done = 1'b0;
  logic [31:0] q_exp[$];
  bit          q_sel[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  acpi_pm_evt #(.TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .size32(size32),
    .addr(addr), .wdata(wdata), .rdata(rdata), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
    .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt), .glbl_evt(glbl_evt),
    .sci(sci), .soft_off_req(soft_off_req), .reset_req(reset_req)
  );

  initial forever begin
    @(negedge clk);
    #1;
    if (mon_vld && q_exp.size() > 0) begin
      logic [31:0] e, a;
      bit s;
      string t;
      e = q_exp.pop_front(); s = q_sel.pop_front(); t = q_tag.pop_front();
      a = s ? {29'd0, sci, soft_off_req, reset_req} : rdata;
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic push(input bit s, input logic [31:0] e, input string t);
    q_sel.push_back(s); q_exp.push_back(e); q_tag.push_back(t);
    mon_vld = 1'b1;
    @(posedge clk); #1;
    mon_vld = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input bit s32, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; size32 = s32;
    push(1'b0, e, t);
  endtask

  task automatic outs(input logic [2:0] e, input string t);
    @(negedge clk);
    push(1'b1, {29'd0, e}, t);
  endtask

  task automatic wr(input logic [5:0] a, input bit s32, input logic [15:0] d);
    @(negedge clk);
    addr = a; size32 = s32; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic apm(input logic [7:0] c);
    @(negedge clk);
    apm_cmd = c; apm_wr = 1'b1;
    @(posedge clk); #1;
    apm_wr = 1'b0;
  endtask

  task automatic evt(input int which);
    @(negedge clk);
    if (which == 0) pwrbtn_evt = 1'b1;
    else if (which == 1) rtc_evt = 1'b1;
    else glbl_evt = 1'b1;
    @(posedge clk); #1;
    pwrbtn_evt = 1'b0; rtc_evt = 1'b0; glbl_evt = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(6'h00, 0, 32'h0, "R1 status");
    rd(6'h02, 0, 32'h0, "R1 enable");
    rd(6'h04, 0, 32'h0, "R1 control");
    rd(6'h08, 1, 32'h0, "R1 timer");
    outs(3'b000, "R1 outputs");

    evt(0);
    rd(6'h00, 0, 32'h0, "R11 button ignored while disabled");
    wr(6'h02, 0, 16'h0100);
    evt(0);
    rd(6'h00, 0, 32'h0100, "R11 button sets status");
    outs(3'b100, "R7 sci from button");

    evt(1);
    evt(2);
    rd(6'h00, 0, 32'h0520, "R12 rtc and global lock status");
    wr(6'h02, 0, 16'h0000);
    outs(3'b000, "R7 sci gated by enables");
    wr(6'h02, 0, 16'h0400);
    outs(3'b100, "R7 sci from rtc");

    wr(6'h00, 0, 16'h0500);
    rd(6'h00, 0, 32'h0020, "R4 selective clear");
    outs(3'b000, "R7 sci drops after clear");
    wr(6'h00, 0, 16'h0000);
    rd(6'h00, 0, 32'h0020, "R4 zero write keeps bits");
    wr(6'h00, 0, 16'h0020);
    rd(6'h00, 0, 32'h0, "R4 last bit cleared");

    wr(6'h02, 1, 16'hFFFF);
    rd(6'h02, 0, 32'h0400, "R2 32-bit write ignored");
    rd(6'h06, 0, 32'h0, "R2 undecoded offset");
    rd(6'h02, 1, 32'h0, "R2 wrong size at enable");
    rd(6'h08, 0, 32'h0, "R2 16-bit read of timer offset");

    wr(6'h04, 0, 16'h3C05);
    outs(3'b000, "R9 sleep type 7 no request");
    rd(6'h04, 0, 32'h1C05, "R8 control stored without sleep-enable");

    apm(8'hF0);
    rd(6'h04, 0, 32'h1C04, "R10 apm off");
    apm(8'h55);
    rd(6'h04, 0, 32'h1C04, "R10 other command ignored");
    apm(8'hF1);
    rd(6'h04, 0, 32'h1C05, "R10 apm on");

    wr(6'h04, 0, 16'h2000);
    outs(3'b010, "R9 soft-off pulse");
    outs(3'b000, "R9 soft-off one cycle");
    rd(6'h04, 0, 32'h0, "R8 control after type 0");
    wr(6'h04, 0, 16'h2400);
    outs(3'b001, "R9 reset pulse");
    outs(3'b000, "R9 reset one cycle");
    rd(6'h00, 0, 32'h8100, "R9 wake and button status");
    rd(6'h04, 0, 32'h0400, "R8 control after type 1");
    wr(6'h04, 0, 16'h0400);
    outs(3'b000, "R9 no request without sleep-enable");

    wr(6'h00, 0, 16'hFFFF);
    rd(6'h00, 0, 32'h0, "R4 clear all");
    wr(6'h02, 0, 16'h0001);
    run(511);
    rd(6'h08, 1, 32'h1FF, "R3 count");
    rd(6'h00, 0, 32'h0, "R5 not set before top bit");
    run(1);
    rd(6'h08, 1, 32'h200, "R3 count at top bit");
    rd(6'h00, 0, 32'h0001, "R5 timer status set");
    outs(3'b100, "R7 sci from timer");
    wr(6'h00, 0, 16'h0001);
    rd(6'h00, 0, 32'h0, "R6 cleared");
    rd(6'h00, 0, 32'h0, "R6 re-armed stays clear");
    outs(3'b000, "R7 sci low after timer clear");
    run(511);
    rd(6'h08, 1, 32'h3FF, "R3 count at all-ones");
    rd(6'h00, 0, 32'h0, "R6 not set before next change");
    run(1);
    rd(6'h08, 1, 32'h0, "R3 wrap to zero");
    rd(6'h00, 0, 32'h0001, "R6 set at next top-bit change");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      finish_up();
    end
  end
endmodule